// File: doc/BRIEF.md
# Mailbox Handshake Resolver with Watchdog

This block is the per-node arbiter for mailbox traffic in a mesh of processor nodes. Each node has one bus to each neighbour. On every bus it can have an outbound request (the node wants the neighbour's mailbox) and an inbound request (the neighbour wants this node's mailbox). When its queue is empty, the resolver takes a snapshot of all pending requests into a circular request queue. It then presents one queue entry per memory cycle. One clock edge is one memory cycle.

An outbound entry drives the service select for its bus. The entry counts as complete when the neighbour's acknowledge arrives in that same cycle. An inbound entry is granted with a single-cycle acknowledge out, unless a memory refresh is pending. An entry that fails moves to the tail of the queue, so the next entry gets its turn.

A two-level watchdog looks for lockstep deadlock around a ring of nodes. Its first level is a down-counter that is preset on each leading edge of the processor clock. When that counter expires in a node strapped as an alternate node, the node skips one service slot, which shifts its phase relative to its neighbours. When the counter has expired a fixed number of times, the block raises an interrupt, sets the isolation bit for the unresponsive neighbour, and drops the stuck entry.

Top module: `hs_resolver`

## Requirements
- R1: While reset is held and in the first cycle after reset, svcSel, ackOut, reorder, irq and isoSet are all zero and the queue is empty.
- R2: When the queue is empty, the next clock edge loads every active request. Loading runs from the highest bus number down to bus 0, and each bus places its inbound entry before its outbound entry. Buses with no active request are skipped.
- R3: A request that rises while the queue holds entries is not loaded until the queue has drained. The cycle that performs the load presents no entry.
- R4: In any cycle, at most one bit across svcSel and ackOut is set.
- R5: An outbound head entry on bus b whose reqOut[b] is still high sets svcSel[b]. If ackIn[b] is high in that cycle, the entry is deleted. Otherwise it moves to the tail of the queue.
- R6: An inbound head entry on bus b whose reqIn[b] is high sets ackOut[b] for that one cycle and is then deleted. If refreshPend is high, ackOut stays low and the entry moves to the tail instead.
- R7: If the request behind a head entry has dropped, the entry is deleted without driving svcSel or ackOut.
- R8: The watchdog counter loads WD_PRESET when cpuClkLead is high. In every other cycle in which the queue is non-empty, it counts down by one. An expiry occurs in a non-empty cycle without cpuClkLead in which the counter is at 1, and the counter then reloads.
- R9: On an expiry with altNode high that is not an escalation, reorder pulses for one cycle, the head moves to the tail, and no entry is served in that cycle.
- R10: The ESC_COUNT-th expiry since the last cpuClkLead pulses irq, deletes the head entry, and restarts the tally. If that head is outbound on bus b, it also pulses isoSet[b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqOut | input | NB | Outbound mailbox request, one per bus |
| reqIn | input | NB | Inbound mailbox request from each neighbour |
| ackIn | input | NB | Acknowledge from each neighbour |
| refreshPend | input | 1 | Local memory refresh pending |
| cpuClkLead | input | 1 | Leading edge of the local processor clock |
| altNode | input | 1 | Strap: this node reorders on watchdog expiry |
| svcSel | output | NB | Outbound request being served, one-hot |
| ackOut | output | NB | Acknowledge to a neighbour, one-hot |
| reorder | output | 1 | Queue reorder pulse |
| irq | output | 1 | Watchdog escalation interrupt, also releases the processor clock |
| isoSet | output | NB | Set pulse for a neighbour's isolation bit |

## Verification
A directed opening puts two outbound requests on the queue with no acknowledge, so they alternate. This shows that the load order is right and that a failed entry goes to the tail. While those entries circulate, an inbound request is raised, which shows that it is held back until the queue drains. Refresh stalls on an inbound entry, a request that is withdrawn before it is served, and an outbound entry left unanswered long enough to reach the reorder pulse and then the escalation each isolate one path of the control logic. A long random phase then runs with sticky request levels, sparse processor-clock edges, and the alternate-node strap toggled. Every cycle of it is compared against a queue-based model, so that collisions between reordering, refresh and withdrawn requests are exercised.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  // strobes from control to the queue datapath
  typedef struct packed {
    logic load;
    logic pop;
    logic rotate;
  } qCmd_t;
endpackage

// File: rtl/hsr_queue.sv
module hsr_queue
  import hsr_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  qCmd_t                      cmd,
  input  logic [NB-1:0]              reqIn,
  input  logic [NB-1:0]              reqOut,
  output logic [$clog2(NB):0]        headId,
  output logic                       headValid
);
  localparam int BW    = $clog2(NB);
  localparam int IDW   = BW + 1;
  localparam int SLOTS = 2 * NB;
  localparam int CW    = $clog2(SLOTS + 1);

  logic [IDW-1:0] slot     [SLOTS];
  logic [IDW-1:0] loadList [SLOTS];
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  loadCnt;

  // entry id = {bus, dir}; dir 1 = outbound
  always_comb begin
    int fill;
    fill = 0;
    for (int k = 0; k < SLOTS; k++) loadList[k] = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int  bus;
      int  dir;
      logic act;
      bus = NB - 1 - (k / 2);
      dir = k % 2;
      act = (dir == 1) ? reqOut[bus] : reqIn[bus];
      if (act) begin
        loadList[fill] = IDW'(bus * 2 + dir);
        fill++;
      end
    end
    loadCnt = CW'(fill);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else if (cmd.load) begin
      cnt <= loadCnt;
      for (int i = 0; i < SLOTS; i++) slot[i] <= loadList[i];
    end else if (cmd.pop || cmd.rotate) begin
      for (int i = 0; i < SLOTS - 1; i++) slot[i] <= slot[i+1];
      slot[SLOTS-1] <= '0;
      if (cmd.rotate) slot[int'(cnt) - 1] <= slot[0];
      if (cmd.pop) cnt <= cnt - 1'b1;
    end
  end

  assign headId    = slot[0];
  assign headValid = (cnt != '0);
endmodule

// File: rtl/hsr_watchdog.sv
module hsr_watchdog #(
  parameter int WD_PRESET = 8,
  parameter int ESC_COUNT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic cpuClkLead,
  input  logic busy,
  output logic carry,
  output logic escalate
);
  localparam int WDW = $clog2(WD_PRESET + 1);
  localparam int EW  = $clog2(ESC_COUNT + 1);

  logic [WDW-1:0] wdCnt;
  logic [EW-1:0]  escCnt;

  assign carry    = busy && !cpuClkLead && (wdCnt == WDW'(1));
  assign escalate = carry && (escCnt == EW'(ESC_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt  <= WDW'(WD_PRESET);
      escCnt <= '0;
    end else if (cpuClkLead) begin
      wdCnt  <= WDW'(WD_PRESET);
      escCnt <= '0;
    end else if (busy) begin
      if (carry) begin
        wdCnt  <= WDW'(WD_PRESET);
        escCnt <= escalate ? '0 : escCnt + 1'b1;
      end else begin
        wdCnt <= wdCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsr_ctrl.sv
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [$clog2(NB):0] headId,
  input  logic                headValid,
  input  logic [NB-1:0]       reqIn,
  input  logic [NB-1:0]       reqOut,
  input  logic [NB-1:0]       ackIn,
  input  logic                refreshPend,
  input  logic                altNode,
  input  logic                carry,
  input  logic                escalate,
  output qCmd_t               cmd,
  output logic [NB-1:0]       svcSel,
  output logic [NB-1:0]       ackOut,
  output logic                reorder,
  output logic                irq,
  output logic [NB-1:0]       isoSet
);
  localparam int BW = $clog2(NB);

  logic [BW-1:0] headBus;
  logic          headOut;

  assign headBus = headId[BW:1];
  assign headOut = headId[0];

  always_comb begin
    cmd     = '0;
    svcSel  = '0;
    ackOut  = '0;
    reorder = 1'b0;
    irq     = 1'b0;
    isoSet  = '0;
    if (!headValid) begin
      cmd.load = 1'b1;
    end else if (escalate) begin
      irq     = 1'b1;
      cmd.pop = 1'b1;
      if (headOut) isoSet[headBus] = 1'b1;
    end else if (carry && altNode) begin
      reorder    = 1'b1;
      cmd.rotate = 1'b1;
    end else if (headOut) begin
      if (!reqOut[headBus]) begin
        cmd.pop = 1'b1;
      end else begin
        svcSel[headBus] = 1'b1;
        if (ackIn[headBus]) cmd.pop = 1'b1;
        else                cmd.rotate = 1'b1;
      end
    end else begin
      if (!reqIn[headBus]) begin
        cmd.pop = 1'b1;
      end else if (refreshPend) begin
        cmd.rotate = 1'b1;
      end else begin
        ackOut[headBus] = 1'b1;
        cmd.pop         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_resolver.sv
module hs_resolver
  import hsr_pkg::*;
#(
  parameter int NB        = 4,
  parameter int WD_PRESET = 8,
  parameter int ESC_COUNT = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NB-1:0] reqOut,
  input  logic [NB-1:0] reqIn,
  input  logic [NB-1:0] ackIn,
  input  logic          refreshPend,
  input  logic          cpuClkLead,
  input  logic          altNode,
  output logic [NB-1:0] svcSel,
  output logic [NB-1:0] ackOut,
  output logic          reorder,
  output logic          irq,
  output logic [NB-1:0] isoSet
);
  localparam int IDW = $clog2(NB) + 1;

  qCmd_t          cmd;
  logic [IDW-1:0] headId;
  logic           headValid;
  logic           carry;
  logic           escalate;

  hsr_queue #(.NB(NB)) u_queue (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqIn(reqIn), .reqOut(reqOut),
    .headId(headId), .headValid(headValid)
  );

  hsr_watchdog #(.WD_PRESET(WD_PRESET), .ESC_COUNT(ESC_COUNT)) u_wd (
    .clk(clk), .rstN(rstN), .cpuClkLead(cpuClkLead), .busy(headValid),
    .carry(carry), .escalate(escalate)
  );

  hsr_ctrl #(.NB(NB)) u_ctrl (
    .headId(headId), .headValid(headValid), .reqIn(reqIn), .reqOut(reqOut),
    .ackIn(ackIn), .refreshPend(refreshPend), .altNode(altNode),
    .carry(carry), .escalate(escalate), .cmd(cmd), .svcSel(svcSel),
    .ackOut(ackOut), .reorder(reorder), .irq(irq), .isoSet(isoSet)
  );
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic [NB-1:0] reqOut,
  input logic [NB-1:0] reqIn,
  input logic          refreshPend,
  input logic [NB-1:0] svcSel,
  input logic [NB-1:0] ackOut,
  input logic          reorder,
  input logic          irq,
  input logic [NB-1:0] isoSet
);
  AST_ONE_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({svcSel, ackOut}) <= 1); // R4
  AST_ACK_NO_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |-> !refreshPend); // R6
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut & ~reqIn) == '0); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |=> ((ackOut & $past(ackOut)) == '0)); // R6
  AST_SVC_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (svcSel & ~reqOut) == '0); // R7
  AST_REORDER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reorder |-> (svcSel == '0 && ackOut == '0 && !irq)); // R9
  AST_ISO_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|isoSet) |-> (irq && $onehot0(isoSet))); // R10
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (svcSel == '0 && ackOut == '0)); // R10
endmodule

bind hs_resolver hsr_checker #(.NB(NB)) u_chk (
  .clk(clk), .rstN(rstN), .reqOut(reqOut), .reqIn(reqIn),
  .refreshPend(refreshPend), .svcSel(svcSel), .ackOut(ackOut),
  .reorder(reorder), .irq(irq), .isoSet(isoSet)
);

// File: tb/hs_resolver_tb.sv
module hs_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int WDP = 8;
  localparam int ESC = 3;

  logic clk = 1'b0;
  logic rstN;
  logic [NB-1:0] reqOut, reqIn, ackIn, svcSel, ackOut, isoSet;
  logic refreshPend, cpuClkLead, altNode, reorder, irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_resolver #(.NB(NB), .WD_PRESET(WDP), .ESC_COUNT(ESC)) u_dut (
    .clk(clk), .rstN(rstN), .reqOut(reqOut), .reqIn(reqIn), .ackIn(ackIn),
    .refreshPend(refreshPend), .cpuClkLead(cpuClkLead), .altNode(altNode),
    .svcSel(svcSel), .ackOut(ackOut), .reorder(reorder), .irq(irq),
    .isoSet(isoSet)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state
  int mq[$];
  int wd;
  int esc;
  logic [NB-1:0] eSvc, eAck, eIso;
  logic eReo, eIrq;

  function automatic void modelStep();
    int h, b, d;
    bit busy, carry, escal;
    eSvc = '0; eAck = '0; eIso = '0; eReo = 0; eIrq = 0;
    busy  = (mq.size() != 0);
    carry = busy && !cpuClkLead && (wd == 1);
    escal = carry && (esc == ESC - 1);
    if (!busy) begin
      for (int bb = NB - 1; bb >= 0; bb--) begin
        if (reqIn[bb])  mq.push_back(bb * 2);
        if (reqOut[bb]) mq.push_back(bb * 2 + 1);
      end
    end else begin
      h = mq.pop_front(); b = h / 2; d = h % 2;
      if (escal) begin
        eIrq = 1;
        if (d == 1) eIso[b] = 1;
      end else if (carry && altNode) begin
        eReo = 1; mq.push_back(h);
      end else if (d == 1) begin
        if (reqOut[b]) begin
          eSvc[b] = 1;
          if (!ackIn[b]) mq.push_back(h);
        end
      end else begin
        if (reqIn[b]) begin
          if (refreshPend) mq.push_back(h);
          else eAck[b] = 1;
        end
      end
    end
    if (cpuClkLead) begin wd = WDP; esc = 0; end
    else if (busy) begin
      if (carry) begin wd = WDP; esc = escal ? 0 : esc + 1; end
      else wd = wd - 1;
    end
  endfunction

  function automatic void driveCycle(input int cyc);
    reqOut = '0; reqIn = '0; ackIn = '0; refreshPend = 0;
    cpuClkLead = (cyc < 20); altNode = 1;
    if (cyc <= 4)  reqOut = 4'b1010;
    if (cyc == 3)  ackIn = 4'b1000;
    if (cyc == 4)  ackIn = 4'b0010;
    if (cyc >= 2 && cyc <= 10) reqIn[0] = 1;
    if (cyc >= 8 && cyc <= 9)  refreshPend = 1;
    if (cyc == 12) reqOut = 4'b0100;
    if (cyc >= 20 && cyc <= 44) reqOut = 4'b0001;
  endfunction

  initial begin
    rstN = 0; reqOut = '0; reqIn = '0; ackIn = '0;
    refreshPend = 0; cpuClkLead = 0; altNode = 0;
    wd = WDP; esc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(svcSel == 0 && ackOut == 0 && !reorder && !irq && isoSet == 0,
        "R1 reset outputs", {svcSel, ackOut}, 0);
    rstN = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc < 50) driveCycle(cyc);
      else begin
        for (int b = 0; b < NB; b++) begin
          if ($urandom_range(7) == 0) reqOut[b] = ~reqOut[b];
          if ($urandom_range(7) == 0) reqIn[b]  = ~reqIn[b];
          ackIn[b] = ($urandom_range(2) == 0);
        end
        refreshPend = ($urandom_range(5) == 0);
        cpuClkLead  = ($urandom_range(40) == 0);
        altNode     = ((cyc / 500) % 2 == 0);
      end
      #1;
      modelStep();
      if (cyc == 0) chk(svcSel == 0 && ackOut == 0, "R1 first cycle idle", svcSel, 0);
      if (cyc == 1) chk(svcSel == 4'b1000, "R2 bus3 outbound first", svcSel, 4'b1000);
      if (cyc == 2) chk(svcSel == 4'b0010, "R2 bus1 outbound next", svcSel, 4'b0010);
      if (cyc == 3) chk(svcSel == 4'b1000, "R5 failed entry rotated", svcSel, 4'b1000);
      if (cyc == 5) chk(ackOut == 0, "R3 late request waits for drain", ackOut, 0);
      if (cyc == 6) chk(ackOut == 4'b0001, "R6 inbound acknowledged", ackOut, 1);
      if (cyc == 8) chk(ackOut == 0, "R6 refresh withholds ack", ackOut, 0);
      if (cyc == 10) chk(ackOut == 4'b0001, "R6 ack after refresh", ackOut, 1);
      if (cyc == 13) chk(svcSel == 0, "R7 withdrawn request dropped", svcSel, 0);
      if (cyc == 27) chk(svcSel == 4'b0001 && !reorder, "R8 no expiry yet", {reorder, svcSel}, 1);
      if (cyc == 28) chk(reorder && svcSel == 0, "R9 first expiry reorders", {reorder, svcSel}, 16);
      if (cyc == 36) chk(reorder == 1, "R8 second expiry", reorder, 1);
      if (cyc == 44) chk(irq && isoSet == 4'b0001, "R10 escalation isolates bus0", {irq, isoSet}, 17);
      chk($countones({svcSel, ackOut}) <= 1, "R4 single service", {svcSel, ackOut}, 0);
      chk(svcSel == eSvc, "R5 svcSel vs model", svcSel, eSvc);
      chk(ackOut == eAck, "R6 ackOut vs model", ackOut, eAck);
      chk(reorder == eReo, "R8 R9 reorder vs model", reorder, eReo);
      chk(irq == eIrq && isoSet == eIso, "R10 irq/isoSet vs model", {irq, isoSet}, {eIrq, eIso});
      @(posedge clk);
      @(negedge clk);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule